// File: doc/BRIEF.md
# Multi-Line TDM Frame Capture

This block terminates eight time-division-multiplexed serial input lines. Each line carries a 125 µs frame of 32 eight-bit channels, sent most significant bit first at 2.048 Mb/s. The block runs from a 4.096 MHz clock, so every bit cell spans two clock periods. An active-low alignment strobe arrives once per frame, straddling the boundary between the last bit of channel 31 and the first bit of channel 0. From this strobe the block keeps a frame position counter. It samples each line once per bit cell, assembles the bytes, and stores every completed byte in a shared 256-byte capture memory addressed by line and channel.

The current channel number and bit phase are exported so that downstream switching logic can schedule its reads against the capture memory. A combinational read port serves those reads. The eight bytes of one channel are parked in a holding bank when they complete. They are then written one line at a time during the next channel slot, so a single write port is enough.

Top module: `serial_frame_capture`

## Requirements
- R1: While `rst_n` is low, `chan` and `phase` read zero and `wr_en` is low. The capture memory contents are not cleared by reset.
- R2: When `frame_n` is sampled low at a clock edge after being sampled high at the edge before, the next cycle shows `chan` = 0 and `phase` = 0, which is the first half of channel 0 bit 7. Holding `frame_n` low at further edges does not restart the count again.
- R3: In every other cycle the position {`chan`,`phase`} advances by one, wrapping from channel 31 phase 15 to zero. `phase[3:1]` counts bit cells from the MSB (0 means bit 7, 7 means bit 0) and `phase[0]` is the half of the cell.
- R4: Each line is sampled only at the clock edge that ends a cycle with `phase[0]` = 0. The value driven in the second half of a cell has no effect. The first sampled bit of a channel becomes bit 7 of its byte.
- R5: A completed channel is written during the following channel slot, one line per even-phase cycle, in the cycle where `phase` = 2×line, with lines in ascending order.
- R6: The write address is line×32 + channel of the completed byte, with the line in bits 7:5 and the channel in bits 4:0. The write data is the byte received on that line in that channel.
- R7: No byte is written after reset until a first alignment strobe has been seen.
- R8: Channel 31 of a frame is written during channel 0 of the next frame. A byte set that completes at the end of the cell just before a mid-frame realignment is still written, in the first slot after the realignment.
- R9: `rd_data` returns, without a clock delay, the byte most recently written at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two periods per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame alignment strobe |
| rx | input | 8 | Serial data, one bit per line |
| rd_addr | input | 8 | Capture memory read address (line×32 + channel) |
| rd_data | output | 8 | Capture memory read data |
| chan | output | 5 | Current channel slot |
| phase | output | 4 | Bit cell index from MSB (3:1) and half-cell (0) |
| wr_en | output | 1 | Capture memory write strobe |
| wr_addr | output | 8 | Capture memory write address |
| wr_data | output | 8 | Capture memory write data |

## Verification
At the edge that ends phase 14, the holding bank takes the eight new bytes of a channel. At that same edge, the write of line 7 from the previous channel still has to use the old contents. Every channel boundary therefore provokes this collision, and the bench uses a different byte pattern on every line and channel. A scoreboard compares each write's address, data and phase with the queue of expected bytes, so a write that picks up the fresh byte instead of the stale one is reported. A realignment strobe placed on the cycle right after a channel completes puts the restart and the pending write sequence into the same slot. That pending channel must still appear, at its own address, in the first slot after the restart.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
   localparam int unsigned DEF_LINES = 8;
   localparam int unsigned DEF_CHANS = 32;
   localparam int unsigned DEF_WIDTH = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tdmrx_framer.sv
module tdmrx_framer #(
   parameter int unsigned CH_W  = 5,
   parameter int unsigned BIT_W = 3,
   localparam int unsigned POS_W = CH_W + BIT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   output logic [POS_W-1:0] pos,
   output logic             smp_en,
   output logic             byte_done,
   output logic             aligned
);
   logic [POS_W-1:0] pos_q;
   logic             frame_q;
   logic             aligned_q;
   logic             restart;

   // restart only on a high-to-low transition of the sampled strobe
   assign restart = frame_q & ~frame_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= '0;
         frame_q   <= 1'b1;
         aligned_q <= 1'b0;
      end else begin
         frame_q <= frame_n;
         if (restart) begin
            pos_q     <= '0;
            aligned_q <= 1'b1;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   assign pos       = pos_q;
   assign smp_en    = ~pos_q[0];
   assign byte_done = (pos_q[BIT_W:0] == {{BIT_W{1'b1}}, 1'b0});
   assign aligned   = aligned_q;
endmodule

// File: rtl/tdmrx_deser.sv
module tdmrx_deser #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_en,
   input  logic             rx,
   output logic [WIDTH-1:0] byte_o
);
   logic [WIDTH-2:0] sh_q;

   // the byte including the bit being sampled at this edge
   assign byte_o = {sh_q, rx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q <= '0;
      else if (smp_en) sh_q <= byte_o[WIDTH-2:0];
   end
endmodule

// File: rtl/tdmrx_store.sv
module tdmrx_store #(
   parameter int unsigned LINES = 8,
   parameter int unsigned CHANS = 32,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned CH_W   = $clog2(CHANS),
   localparam int unsigned BIT_W  = $clog2(WIDTH),
   localparam int unsigned LN_W   = $clog2(LINES),
   localparam int unsigned ADDR_W = LN_W + CH_W,
   localparam int unsigned DEPTH  = LINES * CHANS,
   localparam int unsigned POS_W  = CH_W + BIT_W + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [POS_W-1:0]            pos,
   input  logic                        byte_done,
   input  logic                        aligned,
   input  logic [LINES-1:0][WIDTH-1:0] bytes_in,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [WIDTH-1:0]            rd_data,
   output logic                        wr_en,
   output logic [ADDR_W-1:0]           wr_addr,
   output logic [WIDTH-1:0]            wr_data
);
   logic [LINES-1:0][WIDTH-1:0] hold_q;
   logic [CH_W-1:0]             hold_ch_q;
   logic                        pend_q;
   logic [BIT_W-1:0]            slot;
   logic                        in_range;
   logic [WIDTH-1:0]            mem [DEPTH];

   assign slot = pos[BIT_W:1];

   generate
      if (LINES == WIDTH) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_part
         assign in_range = (slot < BIT_W'(LINES));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         hold_ch_q <= '0;
         pend_q    <= 1'b0;
      end else if (byte_done && aligned) begin
         hold_q    <= bytes_in;
         hold_ch_q <= pos[POS_W-1:BIT_W+1];
         pend_q    <= 1'b1;
      end
   end

   assign wr_en   = pend_q & ~pos[0] & in_range;
   assign wr_addr = {slot[LN_W-1:0], hold_ch_q};
   assign wr_data = hold_q[slot[LN_W-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serial_frame_capture.sv
module serial_frame_capture
   import tdmrx_pkg::*;
#(
   parameter int unsigned LINES = DEF_LINES,
   parameter int unsigned CHANS = DEF_CHANS,
   parameter int unsigned WIDTH = DEF_WIDTH,
   localparam int unsigned CH_W   = $clog2(CHANS),
   localparam int unsigned BIT_W  = $clog2(WIDTH),
   localparam int unsigned LN_W   = $clog2(LINES),
   localparam int unsigned ADDR_W = LN_W + CH_W,
   localparam int unsigned POS_W  = CH_W + BIT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [LINES-1:0]  rx,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WIDTH-1:0]  rd_data,
   output logic [CH_W-1:0]   chan,
   output logic [BIT_W:0]    phase,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WIDTH-1:0]  wr_data
);
   generate
      if (!is_pow2(LINES)) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (!is_pow2(CHANS)) begin : g_bad_chans
         $error("CHANS must be a power of two of at least 2");
      end
      if (!is_pow2(WIDTH)) begin : g_bad_width
         $error("WIDTH must be a power of two of at least 2");
      end
      if (LINES > WIDTH) begin : g_bad_ratio
         $error("LINES may not exceed WIDTH: one write per bit cell");
      end
   endgenerate

   logic [POS_W-1:0]            pos;
   logic                        smp_en;
   logic                        byte_done;
   logic                        aligned;
   logic [LINES-1:0][WIDTH-1:0] cur_bytes;

   tdmrx_framer #(.CH_W(CH_W), .BIT_W(BIT_W)) i_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .pos       (pos),
      .smp_en    (smp_en),
      .byte_done (byte_done),
      .aligned   (aligned)
   );

   for (genvar i = 0; i < LINES; i++) begin : g_line
      tdmrx_deser #(.WIDTH(WIDTH)) i_deser (
         .clk    (clk),
         .rst_n  (rst_n),
         .smp_en (smp_en),
         .rx     (rx[i]),
         .byte_o (cur_bytes[i])
      );
   end

   tdmrx_store #(.LINES(LINES), .CHANS(CHANS), .WIDTH(WIDTH)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .pos       (pos),
      .byte_done (byte_done),
      .aligned   (aligned),
      .bytes_in  (cur_bytes),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data)
   );

   assign chan  = pos[POS_W-1:BIT_W+1];
   assign phase = pos[BIT_W:0];
endmodule

// File: rtl/tdmrx_checks.sv
module tdmrx_checks #(
   parameter int unsigned CH_W  = 5,
   parameter int unsigned BIT_W = 3,
   parameter int unsigned LN_W  = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_n,
   input logic [CH_W-1:0]      chan,
   input logic [BIT_W:0]       phase,
   input logic                 wr_en,
   input logic [LN_W+CH_W-1:0] wr_addr
);
   logic [CH_W+BIT_W:0] pos_now;
   assign pos_now = {chan, phase};

   // R2: a sampled falling strobe lands the count on channel 0, phase 0
   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(frame_n) && !frame_n) |=> (pos_now == '0));

   // R3: without a falling strobe the position steps by one
   p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !($past(frame_n) && !frame_n))
      |=> (pos_now == $past(pos_now) + 1'b1));

   // R5: writes only in even phases, line taken from the bit-cell index
   p_wr_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!phase[0] && (wr_addr[LN_W+CH_W-1:CH_W] == phase[LN_W:1])));

   // R6: outside the first slot after a restart, the channel written is the previous one
   p_wr_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && chan != '0) |-> (wr_addr[CH_W-1:0] == CH_W'(chan - CH_W'(1))));
endmodule

bind serial_frame_capture tdmrx_checks #(.CH_W(CH_W), .BIT_W(BIT_W), .LN_W(LN_W)) i_checks (
   .clk     (clk),
   .rst_n   (rst_n),
   .frame_n (frame_n),
   .chan    (chan),
   .phase   (phase),
   .wr_en   (wr_en),
   .wr_addr (wr_addr)
);

// File: tb/test_serial_frame_capture.sv
module test_serial_frame_capture;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_n = 1'b1;
   logic [7:0] rx = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [4:0] chan;
   logic [3:0] phase;
   logic       wr_en;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;

   serial_frame_capture i_serial_frame_capture (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .rx(rx),
      .rd_addr(rd_addr), .rd_data(rd_data), .chan(chan), .phase(phase),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [7:0] addr;
      logic [7:0] data;
   } exp_t;

   exp_t       sb_q[$];
   logic [7:0] exp_mem [256];
   bit         written [256];
   int         n_chk = 0;
   int         n_fail = 0;
   int         wr_seen = 0;
   bit         long_pulse = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int f, input int l, input int c);
      case (f)
         0: return 8'((l << 5) | c);
         1: return 8'hA5 ^ 8'(c * 7) ^ 8'(l << 4);
         2: return (c == l || c == 31 - l) ? 8'hFF : 8'h00;
         3: return 8'(l * 29 + c * 11 + 3) ^ 8'(l * c);
         default: return 8'h00;
      endcase
   endfunction

   // drive n cycles of frame f from position 0; the strobe goes low at pulse_at
   task automatic drive(input int f, input int n, input int pulse_at, input bit push);
      for (int p = 0; p < n; p++) begin
         @(negedge clk);
         if (p % 32 == 0 || p == 1) begin
            check(chan == 5'(p >> 4), (p <= 1) ? "R2" : "R3", "chan", chan, p >> 4);
            check(phase == 4'(p & 15), (p <= 1) ? "R2" : "R3", "phase", phase, p & 15);
         end
         for (int l = 0; l < 8; l++) begin
            logic [7:0] b;
            b = pat(f, l, p >> 4);
            // R4: second half of each cell carries the inverted bit
            rx[l] = (p % 2 == 0) ? b[7 - ((p >> 1) & 7)] : ~b[7 - ((p >> 1) & 7)];
         end
         frame_n = !((p == pulse_at) || (p == 0 && long_pulse));
         if (push && (p % 16 == 14)) begin
            for (int l = 0; l < 8; l++) begin
               exp_t e;
               e.addr = 8'(l * 32 + (p >> 4));
               e.data = pat(f, l, p >> 4);
               sb_q.push_back(e);
            end
         end
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         exp_t e;
         wr_seen++;
         if (sb_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 unexpected write: actual addr %0h data %0h expected no write",
                     wr_addr, wr_data);
         end else begin
            e = sb_q.pop_front();
            check(wr_addr == e.addr, "R6", "write address", wr_addr, e.addr);
            check(wr_data == e.data, "R4", "write data", wr_data, e.data);
            check(phase == {wr_addr[7:5], 1'b0}, "R5", "write phase", phase,
                  {wr_addr[7:5], 1'b0});
            exp_mem[e.addr] = e.data;
            written[e.addr] = 1'b1;
         end
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(chan == 0, "R1", "chan in reset", chan, 0);
      check(phase == 0, "R1", "phase in reset", phase, 0);
      check(wr_en == 0, "R1", "wr_en in reset", wr_en, 0);

      @(negedge clk);
      rst_n = 1'b1;
      rx = 8'hFF;
      // R7: free-running count before alignment, bytes complete but are not stored
      for (int k = 1; k < 40; k++) begin
         @(negedge clk);
         if (k == 20) begin
            check(chan == 1, "R3", "chan before alignment", chan, 1);
            check(phase == 4, "R3", "phase before alignment", phase, 4);
         end
         rx = (k % 2 == 0) ? 8'hFF : 8'h3C;
         frame_n = (k == 39) ? 1'b0 : 1'b1;
      end
      check(wr_seen == 0, "R7", "writes before alignment", wr_seen, 0);

      drive(0, 512, 511, 1'b1);
      drive(1, 512, 511, 1'b1);
      // R2: strobe held low across two edges restarts once
      long_pulse = 1'b1;
      // R8: realignment right after channel 12 completes
      drive(2, 208, 207, 1'b1);
      long_pulse = 1'b0;
      drive(3, 512, 511, 1'b1);
      // R8: channel 31 of frame 3 is stored during channel 0 of the next slot
      drive(4, 16, -1, 1'b0);
      rst_n = 1'b0;
      #1;
      check(sb_q.size() == 0, "R8", "pending expected writes", sb_q.size(), 0);

      @(negedge clk);
      check(chan == 0, "R1", "chan after reset", chan, 0);
      check(phase == 0, "R1", "phase after reset", phase, 0);
      check(wr_en == 0, "R1", "wr_en after reset", wr_en, 0);

      // R9: read back all stored bytes, held across reset
      for (int a = 0; a < 256; a++) begin
         rd_addr = 8'(a);
         #1;
         if (written[a])
            check(rd_data == exp_mem[a], "R9", "read data", rd_data, exp_mem[a]);
         else
            check(1'b0, "R9", "address never written", a, 1);
      end

      summary();
      $finish;
   end
endmodule